// File: doc/BRIEF.md
# GPIO Line Interrupt Event Detector

This block sits beside one bank of general-purpose input lines and turns their synchronized levels into interrupt status. Each line has its own three-bit trigger code that picks one of five conditions: a falling edge, a rising edge, either edge, a low level or a high level. When a line's condition is met, the status bit with the same index as the line is set and stays set until software reads the status.

Reading the status is signalled with a one-cycle strobe. The status contents are presented on the status output during that cycle, and the register is cleared at the following clock edge. No separate acknowledge exists. An event detected in the same cycle as the read is not lost: it is set again by the same clock edge that performs the clear. A per-line mask vector decides which status bits may raise the bank's single interrupt output. Masked lines still record their status, so software can poll them.

Edges are found by comparing each line's registered sample with the sample taken one cycle earlier. The block holds edge reporting off until two input samples have been taken after reset, so the reset value of the sample registers never shows up as an edge.

Top module: `gpio_evt_detect`

## Requirements
- R1: With trigger code 1 (bits [3*i+2:3*i] of `trig_sel` for line i), a 0-to-1 transition on `pin_in[i]` sets `stat_q[i]` two clock edges after the new level is presented; a 1-to-0 transition does not.
- R2: With trigger code 0, a 1-to-0 transition on `pin_in[i]` sets `stat_q[i]` two clock edges later; a 0-to-1 transition does not.
- R3: With trigger code 2, both a 0-to-1 and a 1-to-0 transition set `stat_q[i]`.
- R4: With trigger code 3 a low level, and with trigger code 4 a high level, sets `stat_q[i]` for as long as the level is present, including on the clock edge that performs a read, so the bit still reads as set after the read.
- R5: Trigger codes 5, 6 and 7 never set a status bit, whatever the line does.
- R6: An event on line i sets only `stat_q[i]`, and a set status bit holds its value until a read strobe.
- R7: When `stat_rd` is high at a clock edge, every status bit is cleared at that edge except those whose line reports an event in the same cycle, which end up set.
- R8: `bank_irq` is high exactly when some bit is set in both `stat_q` and `irq_mask`; a line whose mask bit is 0 still sets its status bit.
- R9: During reset `stat_q` is all zeros and `bank_irq` is low, and a line held high through reset release with trigger code 1 produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | LINES (32) | Synchronized line levels, bit i is line i |
| trig_sel | input | 3*LINES (96) | Trigger code per line, line i in bits [3*i+2:3*i] |
| irq_mask | input | LINES (32) | Per-line interrupt enable, 1 lets the status bit drive `bank_irq` |
| stat_rd | input | 1 | Status read strobe, clears the status at the next clock edge |
| stat_q | output | LINES (32) | Current status contents |
| bank_irq | output | 1 | Bank interrupt, high while any unmasked status bit is set |

## Verification
The assertions check on every cycle that the status register holds what it had plus newly detected events when there is no read, that a read leaves only the events of that cycle, that unused trigger codes never produce an event, and that the interrupt never rises without a status bit or with an all-zero mask. Only the scenarios can show that each trigger code reacts to the right pin pattern with the two-edge latency, that the line index maps to the matching status bit, that a level-triggered bit survives a read, and that no spurious edge appears at reset release.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int TRIG_W = 3;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_HIGH = 3'd4
    } trig_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    function automatic logic trig_hit(
        input logic [TRIG_W-1:0] sel,
        input pin_hist_t         h,
        input logic              edge_ok
    );
        logic rise;
        logic fall;
        rise = edge_ok & h.cur & ~h.prev;
        fall = edge_ok & ~h.cur & h.prev;
        case (sel)
            TRIG_FALL: return fall;
            TRIG_RISE: return rise;
            TRIG_BOTH: return rise | fall;
            TRIG_LOW:  return ~h.cur;
            TRIG_HIGH: return h.cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_evt_sample.sv
module gpio_evt_sample
    import gpio_evt_pkg::*;
#(
    parameter int LINES    = 32,
    parameter int ARM_CYC  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LINES-1:0]          pin_in,
    output pin_hist_t [LINES-1:0]     hist,
    output logic                      edge_ok
);
    logic [LINES-1:0]   cur_r;
    logic [LINES-1:0]   prev_r;
    logic [ARM_CYC-1:0] arm_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_r  <= '0;
            prev_r <= '0;
            arm_r  <= '0;
        end else begin
            cur_r  <= pin_in;
            prev_r <= cur_r;
            arm_r  <= {arm_r[ARM_CYC-2:0], 1'b1};
        end
    end

    assign edge_ok = arm_r[ARM_CYC-1];

    for (genvar g = 0; g < LINES; g++) begin : g_hist
        assign hist[g].cur  = cur_r[g];
        assign hist[g].prev = prev_r[g];
    end
endmodule

// File: rtl/gpio_evt_line.sv
module gpio_evt_line
    import gpio_evt_pkg::*;
(
    input  logic [TRIG_W-1:0] sel,
    input  pin_hist_t         hist,
    input  logic              edge_ok,
    output logic              hit
);
    always_comb begin
        hit = trig_hit(sel, hist, edge_ok);
    end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] hit,
    input  logic [LINES-1:0] irq_mask,
    input  logic             stat_rd,
    output logic [LINES-1:0] stat_q,
    output logic             bank_irq
);
    logic [LINES-1:0] stat_r;
    logic [LINES-1:0] keep;

    assign keep = stat_rd ? '0 : stat_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_r <= '0;
        end else begin
            stat_r <= keep | hit;
        end
    end

    assign stat_q   = stat_r;
    assign bank_irq = |(stat_r & irq_mask);
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int LINES = 32,
    localparam int SEL_BITS = LINES * TRIG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINES-1:0]    pin_in,
    input  logic [SEL_BITS-1:0] trig_sel,
    input  logic [LINES-1:0]    irq_mask,
    input  logic                stat_rd,
    output logic [LINES-1:0]    stat_q,
    output logic                bank_irq
);
    pin_hist_t [LINES-1:0] hist;
    logic                  edge_ok;
    logic [LINES-1:0]      line_hit;

    gpio_evt_sample #(.LINES(LINES), .ARM_CYC(2)) u_sample (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .hist    (hist),
        .edge_ok (edge_ok)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        gpio_evt_line u_line (
            .sel     (trig_sel[g*TRIG_W +: TRIG_W]),
            .hist    (hist[g]),
            .edge_ok (edge_ok),
            .hit     (line_hit[g])
        );
    end

    gpio_evt_status #(.LINES(LINES)) u_status (
        .clk      (clk),
        .rst      (rst),
        .hit      (line_hit),
        .irq_mask (irq_mask),
        .stat_rd  (stat_rd),
        .stat_q   (stat_q),
        .bank_irq (bank_irq)
    );
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int LINES = 32,
    localparam int SEL_BITS = LINES * TRIG_W
) (
    input logic                clk,
    input logic                rst,
    input logic [SEL_BITS-1:0] trig_sel,
    input logic [LINES-1:0]    irq_mask,
    input logic                stat_rd,
    input logic [LINES-1:0]    stat_q,
    input logic                bank_irq,
    input logic [LINES-1:0]    line_hit
);
    logic             alive;
    logic [LINES-1:0] unused_code;

    always_ff @(posedge clk) begin
        if (rst) alive <= 1'b0;
        else     alive <= 1'b1;
    end

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            unused_code[i] = (trig_sel[i*TRIG_W +: TRIG_W] > 3'd4);
        end
    end

    AST_STATUS_ACCUM: assert property (@(posedge clk) disable iff (rst || !alive)
        !stat_rd |=> stat_q == ($past(stat_q) | $past(line_hit)));   // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst || !alive)
        stat_rd |=> stat_q == $past(line_hit));   // R7

    AST_UNUSED_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (line_hit & unused_code) == '0);   // R5

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        bank_irq |-> (stat_q != '0));   // R8

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !bank_irq);   // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (stat_q == '0) && !bank_irq);   // R9
endmodule

bind gpio_evt_detect gpio_evt_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_sel (trig_sel),
    .irq_mask (irq_mask),
    .stat_rd  (stat_rd),
    .stat_q   (stat_q),
    .bank_irq (bank_irq),
    .line_hit (line_hit)
);

// File: tb/test_gpio_evt_detect.sv
`timescale 1ns/1ps
module test_gpio_evt_detect;
    localparam int LINES = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LINES-1:0]  pin_in = '0;
    logic [3*LINES-1:0] trig_sel = '1;
    logic [LINES-1:0]  irq_mask = '0;
    logic              stat_rd = 1'b0;
    logic [LINES-1:0]  stat_q;
    logic              bank_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_evt_detect #(.LINES(LINES)) i_gpio_evt_detect (
        .clk(clk), .rst(rst), .pin_in(pin_in), .trig_sel(trig_sel),
        .irq_mask(irq_mask), .stat_rd(stat_rd), .stat_q(stat_q), .bank_irq(bank_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(input int line, input logic [2:0] code);
        trig_sel[line*3 +: 3] = code;
    endtask

    // Park every line on an unused code and drain the status.
    task automatic quiesce();
        trig_sel = '1;
        step(2);
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        set_sel(0, 3'd1);
        pin_in[0] = 1'b1;
        step(3);
        chk("R9 status in reset", 64'(stat_q), 64'd0);
        chk("R9 irq in reset", 64'(bank_irq), 64'd0);
        rst = 1'b0;
        step(5);
        chk("R9 no edge at release", 64'(stat_q), 64'd0);
        pin_in[0] = 1'b0;
        step(3);
        quiesce();
    endtask

    task automatic t_rise();
        set_sel(2, 3'd1);
        pin_in[2] = 1'b1;
        step(1);
        chk("R1 not yet after one edge", 64'(stat_q[2]), 64'd0);
        step(1);
        chk("R1 rising sets bit 2", 64'(stat_q), 64'h4);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        pin_in[2] = 1'b0;
        step(3);
        chk("R1 falling ignored", 64'(stat_q), 64'd0);
        quiesce();
    endtask

    task automatic t_fall();
        pin_in[7] = 1'b1;
        step(3);
        set_sel(7, 3'd0);
        step(2);
        chk("R2 no event on steady high", 64'(stat_q), 64'd0);
        pin_in[7] = 1'b0;
        step(2);
        chk("R2 falling sets bit 7", 64'(stat_q), 64'h80);
        quiesce();
        set_sel(7, 3'd0);
        pin_in[7] = 1'b1;
        step(3);
        chk("R2 rising ignored", 64'(stat_q), 64'd0);
        pin_in[7] = 1'b0;
        quiesce();
    endtask

    task automatic t_both();
        set_sel(31, 3'd2);
        pin_in[31] = 1'b1;
        step(2);
        chk("R3 rising seen", 64'(stat_q), 64'h8000_0000);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R3 cleared", 64'(stat_q), 64'd0);
        pin_in[31] = 1'b0;
        step(2);
        chk("R3 falling seen", 64'(stat_q), 64'h8000_0000);
        quiesce();
    endtask

    task automatic t_level();
        set_sel(4, 3'd4);
        pin_in[4] = 1'b1;
        step(2);
        chk("R4 high level sets", 64'(stat_q), 64'h10);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R4 high level survives read", 64'(stat_q), 64'h10);
        pin_in[4] = 1'b0;
        step(2);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R4 gone after level drops", 64'(stat_q), 64'd0);
        set_sel(9, 3'd3);
        step(1);
        chk("R4 low level sets", 64'(stat_q), 64'h200);
        quiesce();
    endtask

    task automatic t_nosel();
        for (int c = 5; c < 8; c++) begin
            set_sel(12, 3'(c));
            pin_in[12] = 1'b1; step(3);
            pin_in[12] = 1'b0; step(3);
            chk("R5 unused code quiet", 64'(stat_q), 64'd0);
        end
        quiesce();
    endtask

    task automatic t_index();
        for (int l = 0; l < LINES; l += 5) begin
            set_sel(l, 3'd1);
            pin_in[l] = 1'b1;
            step(2);
            chk("R6 only own bit", 64'(stat_q), 64'(32'd1 << l));
            step(4);
            chk("R6 bit holds", 64'(stat_q), 64'(32'd1 << l));
            pin_in[l] = 1'b0;
            quiesce();
        end
    endtask

    task automatic t_collide();
        set_sel(1, 3'd1);
        set_sel(3, 3'd1);
        pin_in[1] = 1'b1;
        step(2);
        chk("R7 precondition", 64'(stat_q), 64'h2);
        pin_in[3] = 1'b1;
        step(1);
        stat_rd = 1'b1;
        chk("R7 read shows contents", 64'(stat_q), 64'h2);
        step(1);
        stat_rd = 1'b0;
        chk("R7 same-cycle event kept", 64'(stat_q), 64'h8);
        pin_in[1] = 1'b0; pin_in[3] = 1'b0;
        quiesce();
    endtask

    task automatic t_mask();
        set_sel(6, 3'd1);
        irq_mask = '0;
        pin_in[6] = 1'b1;
        step(2);
        chk("R8 masked still records", 64'(stat_q), 64'h40);
        chk("R8 masked no irq", 64'(bank_irq), 64'd0);
        irq_mask = 32'h0000_0020;
        #1;
        chk("R8 other mask no irq", 64'(bank_irq), 64'd0);
        irq_mask = 32'h0000_0040;
        #1;
        chk("R8 unmasked irq", 64'(bank_irq), 64'd1);
        step(1);
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
        chk("R8 irq drops after read", 64'(bank_irq), 64'd0);
        pin_in[6] = 1'b0;
        irq_mask = '0;
        quiesce();
    endtask

    initial begin
        step(1);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_nosel();
        t_index();
        t_collide();
        t_mask();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule